// File: doc/BRIEF.md
# Sixteen-bit compare timer with waveform output

This block is an up-counting timer whose advance is gated by a one-cycle enable pulse (`tick`) from an external divider. Software can load the count at any moment. It can also load a compare value, an alternative top value and a 4-bit mode code. A 2-bit output-action code sets what a compare match does to a single waveform pin: nothing, toggle, clear or set.

Two non-PWM counting schemes are supported. In the free-running scheme the count wraps from all-ones to zero and raises a sticky overflow flag. In the clear-on-match scheme the count returns to zero after it reaches a top value. The top value is either the compare register or the alternative top register, chosen by the mode code. A force strobe applies the current output action to the pin at once. A compare-match flag records each match until it is acknowledged.

Top module: `wave_timer`

## Requirements
- R1: After reset the count is 0, both flags are 0, the waveform pin is 0, the mode is 0 and the output action is 00.
- R2: In mode 0, and in every mode code other than 4 (4'b0100) and 12 (4'b1100), the count rises by one on each cycle with `tick` high. It holds when `tick` is low, wraps from 0xFFFF to 0x0000, and is never cleared by a compare match.
- R3: The overflow flag is set at the same clock edge at which a tick moves the count from 0xFFFF to 0. It stays set until `ovf_ack`. A new setting wins over an acknowledge in the same cycle.
- R4: In mode 4, a tick while the count equals the compare register loads 0 instead of incrementing.
- R5: In mode 12, a tick while the count equals the alternative top register loads 0. A match against the compare register in this mode sets the match flag but does not clear the count.
- R6: A compare match happens on a cycle with `tick` high, no counter write, and the count equal to the compare register. The match sets the match flag, which stays set until `match_ack`. A new setting wins over an acknowledge.
- R7: A counter write loads `cnt_wr_data` at the next edge in any mode and takes priority over the tick. In that cycle it also blocks the compare match (flag and pin) and the overflow.
- R8: On a compare match the pin follows the output-action code: 00 leaves it unchanged, 01 toggles it, 10 clears it and 11 sets it. The pin does not change without a match or a force.
- R9: A newly written output-action code acts only from the next compare match onward. A match in the same cycle as the write uses the previous code.
- R10: A `force_cmp` pulse applies the current output action to the pin at the next edge. It does not set the match flag and does not change the count. A force together with a match applies the action once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable pulse |
| cnt_wr_en | input | 1 | Counter load strobe |
| cnt_wr_data | input | CNT_W | Counter load value |
| cmp_wr_en | input | 1 | Compare register write strobe |
| cmp_wr_data | input | CNT_W | Compare register value |
| cap_wr_en | input | 1 | Alternative top register write strobe |
| cap_wr_data | input | CNT_W | Alternative top value |
| mode_wr_en | input | 1 | Mode code write strobe |
| mode_wr_data | input | 4 | Mode code |
| act_wr_en | input | 1 | Output-action write strobe |
| act_wr_data | input | 2 | Output-action code |
| force_cmp | input | 1 | Force-compare strobe |
| ovf_ack | input | 1 | Clears the overflow flag |
| match_ack | input | 1 | Clears the match flag |
| cnt_o | output | CNT_W | Current count |
| wave_o | output | 1 | Waveform pin |
| ovf_flag_o | output | 1 | Overflow flag |
| match_flag_o | output | 1 | Compare-match flag |

## Verification
The bench builds the block with the default width of 16 bits, so the wrap from 0xFFFF and the overflow edge are real. It reaches them by loading 0xFFFE directly rather than counting up. The random phase keeps compare and top values below 24 and draws mode codes from 0, 4, 12 and an unassigned code. This makes matches, clears, same-cycle write/match collisions and force/match overlaps frequent within a few thousand cycles.

// File: rtl/wave_timer_pkg.sv
package wave_timer_pkg;

    localparam int MODE_W = 4;
    localparam int ACT_W  = 2;

    localparam logic [MODE_W-1:0] MODE_CLR_CMP = 4'd4;
    localparam logic [MODE_W-1:0] MODE_CLR_CAP = 4'd12;

    typedef enum logic [ACT_W-1:0] {
        ACT_KEEP   = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_CLEAR  = 2'b10,
        ACT_SET    = 2'b11
    } act_e;

    function automatic logic apply_act(input act_e a, input logic pin);
        case (a)
            ACT_TOGGLE: return ~pin;
            ACT_CLEAR:  return 1'b0;
            ACT_SET:    return 1'b1;
            default:    return pin;
        endcase
    endfunction

endpackage

// File: rtl/wt_cfg_regs.sv
module wt_cfg_regs
    import wave_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_wr_en,
    input  logic [CNT_W-1:0]  cmp_wr_data,
    input  logic              cap_wr_en,
    input  logic [CNT_W-1:0]  cap_wr_data,
    input  logic              mode_wr_en,
    input  logic [MODE_W-1:0] mode_wr_data,
    input  logic              act_wr_en,
    input  logic [ACT_W-1:0]  act_wr_data,
    output logic [CNT_W-1:0]  cmp_o,
    output logic [CNT_W-1:0]  top_o,
    output logic              clr_en_o,
    output act_e              act_o
);

    typedef struct packed {
        logic [CNT_W-1:0]  cmp;
        logic [CNT_W-1:0]  cap;
        logic [MODE_W-1:0] mode;
        act_e              act;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cmp_wr_en)  cfg_d.cmp  = cmp_wr_data;
        if (cap_wr_en)  cfg_d.cap  = cap_wr_data;
        if (mode_wr_en) cfg_d.mode = mode_wr_data;
        if (act_wr_en)  cfg_d.act  = act_e'(act_wr_data);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '{cmp: '0, cap: '0, mode: '0, act: ACT_KEEP};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        clr_en_o = (cfg_q.mode == MODE_CLR_CMP) || (cfg_q.mode == MODE_CLR_CAP);
        top_o    = (cfg_q.mode == MODE_CLR_CAP) ? cfg_q.cap : cfg_q.cmp;
        cmp_o    = cfg_q.cmp;
        act_o    = cfg_q.act;
    end

    AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !act_wr_en |=> act_o == $past(act_o));  // R9

endmodule

// File: rtl/wt_count_core.sv
module wt_count_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cnt_wr_en,
    input  logic [CNT_W-1:0] cnt_wr_data,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic [CNT_W-1:0] top_i,
    input  logic             clr_en_i,
    input  logic             ovf_ack,
    input  logic             match_ack,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_o,
    output logic             match_flag_o,
    output logic             match_evt_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ovf;
        logic             mflag;
    } core_t;

    core_t core_d, core_q;
    logic  step_ok;
    logic  at_top;
    logic  hit_cmp;

    always_comb begin
        step_ok = tick && !cnt_wr_en;
        at_top  = clr_en_i && (core_q.cnt == top_i);
        hit_cmp = step_ok && (core_q.cnt == cmp_i);

        core_d = core_q;
        if (cnt_wr_en) begin
            core_d.cnt = cnt_wr_data;
        end else if (tick) begin
            core_d.cnt = at_top ? '0 : core_q.cnt + CNT_ONE;
        end

        if (step_ok && core_q.cnt == CNT_MAX) begin
            core_d.ovf = 1'b1;
        end else if (ovf_ack) begin
            core_d.ovf = 1'b0;
        end

        if (hit_cmp) begin
            core_d.mflag = 1'b1;
        end else if (match_ack) begin
            core_d.mflag = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_q <= '0;
        end else begin
            core_q <= core_d;
        end
    end

    assign cnt_o        = core_q.cnt;
    assign ovf_o        = core_q.ovf;
    assign match_flag_o = core_q.mflag;
    assign match_evt_o  = hit_cmp;

    AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_wr_en) |=> $stable(cnt_o));  // R2
    AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr_en |=> cnt_o == $past(cnt_wr_data));  // R7
    AST_OVF_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr_en && cnt_o == CNT_MAX) |=> (ovf_o && cnt_o == '0));  // R3
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !ovf_ack) |=> ovf_o);  // R3
    AST_TOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr_en && clr_en_i && cnt_o == top_i) |=> cnt_o == '0);  // R4
    AST_MFLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(match_flag_o) |-> $past(tick && !cnt_wr_en && cnt_o == cmp_i));  // R6

endmodule

// File: rtl/wt_wave_gen.sv
module wt_wave_gen
    import wave_timer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic match_evt_i,
    input  logic force_i,
    input  act_e act_i,
    output logic wave_o
);

    typedef struct packed {
        logic pin;
    } wave_t;

    wave_t wave_d, wave_q;

    always_comb begin
        wave_d = wave_q;
        if (match_evt_i || force_i) begin
            wave_d.pin = apply_act(act_i, wave_q.pin);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wave_q <= '0;
        end else begin
            wave_q <= wave_d;
        end
    end

    assign wave_o = wave_q.pin;

    AST_PIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!match_evt_i && !force_i) |=> $stable(wave_o));  // R8
    AST_PIN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ((match_evt_i || force_i) && act_i == ACT_SET) |=> wave_o);  // R8
    AST_PIN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ((match_evt_i || force_i) && act_i == ACT_CLEAR) |=> !wave_o);  // R10

endmodule

// File: rtl/wave_timer.sv
module wave_timer
    import wave_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cnt_wr_en,
    input  logic [CNT_W-1:0] cnt_wr_data,
    input  logic             cmp_wr_en,
    input  logic [CNT_W-1:0] cmp_wr_data,
    input  logic             cap_wr_en,
    input  logic [CNT_W-1:0] cap_wr_data,
    input  logic             mode_wr_en,
    input  logic [3:0]       mode_wr_data,
    input  logic             act_wr_en,
    input  logic [1:0]       act_wr_data,
    input  logic             force_cmp,
    input  logic             ovf_ack,
    input  logic             match_ack,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wave_o,
    output logic             ovf_flag_o,
    output logic             match_flag_o
);

    logic [CNT_W-1:0] cmp_w;
    logic [CNT_W-1:0] top_w;
    logic             clr_en_w;
    act_e             act_w;
    logic             match_evt_w;

    wt_cfg_regs #(.CNT_W(CNT_W)) cfg_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmp_wr_en    (cmp_wr_en),
        .cmp_wr_data  (cmp_wr_data),
        .cap_wr_en    (cap_wr_en),
        .cap_wr_data  (cap_wr_data),
        .mode_wr_en   (mode_wr_en),
        .mode_wr_data (mode_wr_data),
        .act_wr_en    (act_wr_en),
        .act_wr_data  (act_wr_data),
        .cmp_o        (cmp_w),
        .top_o        (top_w),
        .clr_en_o     (clr_en_w),
        .act_o        (act_w)
    );

    wt_count_core #(.CNT_W(CNT_W)) core_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .cnt_wr_en    (cnt_wr_en),
        .cnt_wr_data  (cnt_wr_data),
        .cmp_i        (cmp_w),
        .top_i        (top_w),
        .clr_en_i     (clr_en_w),
        .ovf_ack      (ovf_ack),
        .match_ack    (match_ack),
        .cnt_o        (cnt_o),
        .ovf_o        (ovf_flag_o),
        .match_flag_o (match_flag_o),
        .match_evt_o  (match_evt_w)
    );

    wt_wave_gen wave_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .match_evt_i (match_evt_w),
        .force_i     (force_cmp),
        .act_i       (act_w),
        .wave_o      (wave_o)
    );

    AST_FORCE_NO_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        (force_cmp && !tick && !cnt_wr_en) |=> $stable(cnt_o));  // R10
    AST_FORCE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (force_cmp && !match_flag_o && !(tick && !cnt_wr_en && cnt_o == cmp_w))
        |=> !match_flag_o);  // R10

endmodule

// File: tb/wave_timer_tb_top.sv
module wave_timer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick = 1'b0;
    logic         cnt_wr_en = 1'b0;
    logic [W-1:0] cnt_wr_data = '0;
    logic         cmp_wr_en = 1'b0;
    logic [W-1:0] cmp_wr_data = '0;
    logic         cap_wr_en = 1'b0;
    logic [W-1:0] cap_wr_data = '0;
    logic         mode_wr_en = 1'b0;
    logic [3:0]   mode_wr_data = '0;
    logic         act_wr_en = 1'b0;
    logic [1:0]   act_wr_data = '0;
    logic         force_cmp = 1'b0;
    logic         ovf_ack = 1'b0;
    logic         match_ack = 1'b0;
    logic [W-1:0] cnt_o;
    logic         wave_o;
    logic         ovf_flag_o;
    logic         match_flag_o;

    int checks = 0;
    int fails = 0;

    logic [W-1:0] m_cnt, m_cmp, m_cap;
    logic [3:0]   m_mode;
    logic [1:0]   m_act;
    logic         m_pin, m_ovf, m_mf;

    always #(CLK_PERIOD/2) clk = ~clk;

    wave_timer #(.CNT_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data),
        .cmp_wr_en(cmp_wr_en), .cmp_wr_data(cmp_wr_data),
        .cap_wr_en(cap_wr_en), .cap_wr_data(cap_wr_data),
        .mode_wr_en(mode_wr_en), .mode_wr_data(mode_wr_data),
        .act_wr_en(act_wr_en), .act_wr_data(act_wr_data),
        .force_cmp(force_cmp), .ovf_ack(ovf_ack), .match_ack(match_ack),
        .cnt_o(cnt_o), .wave_o(wave_o),
        .ovf_flag_o(ovf_flag_o), .match_flag_o(match_flag_o)
    );

    function automatic logic exp_pin(input logic [1:0] a, input logic p);
        case (a)
            2'b01:   return ~p;
            2'b10:   return 1'b0;
            2'b11:   return 1'b1;
            default: return p;
        endcase
    endfunction

    task automatic model_next();
        logic         adv = tick && !cnt_wr_en;
        logic         hit = adv && (m_cnt == m_cmp);
        logic         clr = (m_mode == 4'd4) || (m_mode == 4'd12);
        logic [W-1:0] top = (m_mode == 4'd12) ? m_cap : m_cmp;
        logic [W-1:0] n_cnt = m_cnt;
        logic         n_ovf = m_ovf;
        logic         n_mf = m_mf;
        logic         n_pin = m_pin;
        if (cnt_wr_en) n_cnt = cnt_wr_data;
        else if (tick) n_cnt = (clr && m_cnt == top) ? '0 : m_cnt + 1'b1;
        if (adv && m_cnt == 16'hFFFF) n_ovf = 1'b1;
        else if (ovf_ack) n_ovf = 1'b0;
        if (hit) n_mf = 1'b1;
        else if (match_ack) n_mf = 1'b0;
        if (hit || force_cmp) n_pin = exp_pin(m_act, m_pin);
        if (cmp_wr_en)  m_cmp  = cmp_wr_data;
        if (cap_wr_en)  m_cap  = cap_wr_data;
        if (mode_wr_en) m_mode = mode_wr_data;
        if (act_wr_en)  m_act  = act_wr_data;
        m_cnt = n_cnt; m_ovf = n_ovf; m_mf = n_mf; m_pin = n_pin;
    endtask

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic check_all(input string tag);
        check(tag, "count", 32'(cnt_o), 32'(m_cnt));
        check(tag, "pin", 32'(wave_o), 32'(m_pin));
        check(tag, "ovf", 32'(ovf_flag_o), 32'(m_ovf));
        check(tag, "match", 32'(match_flag_o), 32'(m_mf));
    endtask

    task automatic step(input string tag);
        model_next();
        @(posedge clk);
        @(negedge clk);
        cnt_wr_en = 0; cmp_wr_en = 0; cap_wr_en = 0; mode_wr_en = 0;
        act_wr_en = 0; force_cmp = 0; ovf_ack = 0; match_ack = 0;
        check_all(tag);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog R1 actual=hung expected=done");
        summary();
    end

    initial begin
        void'($urandom(32'd4242));
        m_cnt = '0; m_cmp = '0; m_cap = '0; m_mode = '0; m_act = '0;
        m_pin = 0; m_ovf = 0; m_mf = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check_all("R1");

        // R2: plain counting, hold without tick
        tick = 1;
        repeat (5) step("R2");
        tick = 0;
        repeat (3) step("R2");

        // R7 then R3: load near max, wrap, sticky flag, acknowledge
        cnt_wr_en = 1; cnt_wr_data = 16'hFFFE; step("R7");
        tick = 1; step("R3"); step("R3");
        tick = 0; step("R3"); step("R3");
        ovf_ack = 1; step("R3");
        // R3: set wins over ack
        cnt_wr_en = 1; cnt_wr_data = 16'hFFFF; step("R3");
        tick = 1; ovf_ack = 1; step("R3");

        // R4/R8: clear-on-compare with toggle
        tick = 0;
        cmp_wr_en = 1; cmp_wr_data = 16'd5;
        act_wr_en = 1; act_wr_data = 2'b01;
        mode_wr_en = 1; mode_wr_data = 4'd4; step("R8");
        tick = 1; cnt_wr_en = 1; cnt_wr_data = 16'd5; step("R7");
        step("R4");
        repeat (5) step("R4");
        // R9: write at the match cycle uses old code
        act_wr_en = 1; act_wr_data = 2'b11; step("R9");
        repeat (5) step("R9");
        step("R9");
        act_wr_en = 1; act_wr_data = 2'b10; step("R9");
        repeat (6) step("R8");
        // R6: acknowledge with and without a new match
        tick = 0; match_ack = 1; step("R6");
        check("R6", "flag cleared", 32'(match_flag_o), 32'd0);

        // R5: clear on alternative top
        cap_wr_en = 1; cap_wr_data = 16'd3;
        mode_wr_en = 1; mode_wr_data = 4'd12;
        cmp_wr_en = 1; cmp_wr_data = 16'd2;
        cnt_wr_en = 1; cnt_wr_data = 16'd0; step("R5");
        tick = 1;
        repeat (10) step("R5");

        // R10: force with count frozen, and force on a match
        tick = 0; act_wr_en = 1; act_wr_data = 2'b01; match_ack = 1; step("R10");
        force_cmp = 1; step("R10");
        force_cmp = 1; step("R10");
        check("R10", "count unchanged", 32'(cnt_o), 32'(m_cnt));
        cnt_wr_en = 1; cnt_wr_data = 16'd2; step("R10");
        tick = 1; force_cmp = 1; step("R10");

        // R2: unassigned mode acts as free running
        mode_wr_en = 1; mode_wr_data = 4'd7; step("R2");
        repeat (12) step("R2");

        // random phase
        for (int i = 0; i < 4000; i++) begin
            tick = ($urandom % 4) != 0;
            if ($urandom % 40 == 0) begin
                cnt_wr_en = 1;
                cnt_wr_data = ($urandom % 2) ? 16'($urandom % 32) : 16'hFFFD + 16'($urandom % 3);
            end
            if ($urandom % 60 == 0) begin cmp_wr_en = 1; cmp_wr_data = 16'($urandom % 24); end
            if ($urandom % 60 == 0) begin cap_wr_en = 1; cap_wr_data = 16'($urandom % 24); end
            if ($urandom % 80 == 0) begin
                mode_wr_en = 1;
                case ($urandom % 4)
                    0: mode_wr_data = 4'd0;
                    1: mode_wr_data = 4'd4;
                    2: mode_wr_data = 4'd12;
                    default: mode_wr_data = 4'd7;
                endcase
            end
            if ($urandom % 30 == 0) begin act_wr_en = 1; act_wr_data = 2'($urandom); end
            if ($urandom % 25 == 0) force_cmp = 1;
            if ($urandom % 20 == 0) ovf_ack = 1;
            if ($urandom % 20 == 0) match_ack = 1;
            step("R6");
        end

        summary();
    end

endmodule